// File: doc/BRIEF.md
# Masked Event Interrupt Controller with Acknowledge

This block gathers device events into an 8-bit pending register and gates them with an 8-bit enable mask. It drives an active-low interrupt line. Two sources set events. A free-running one-second tick raises the tick event. Peripheral-bus replies raise the bus event. A reply can come back from an explicit bus command, or from an autopoll that the block itself requests at a fixed interval while autopoll is armed. The bus transactions themselves lie outside the block. A reply enters as a one-cycle strobe that carries a byte count and a flat byte buffer.

Software talks to the block through one command strobe that carries an opcode, an argument count and up to two argument bytes. The opcodes are: acknowledge, load the enable mask, set the autopoll device mask, and stop autopoll. An acknowledge returns a reply one cycle later. When a bus reply is pending, the acknowledge hands back only the bus-related event bits together with the stored reply bytes. Every other pending event waits for a later acknowledge.

Top module: `evt_irq_ctrl`

## Requirements
- R1: `irq_n` is low exactly when (pending AND mask) is nonzero, and it follows any change of pending or mask in the same cycle that register changes.
- R2: After reset, pending is 0x00, the mask is 0x90 (bus bit 4 and tick bit 7 enabled), autopoll is off, `irq_n` is high, and `rsp_valid` and `poll_req` are low.
- R3: Pending bit 7 (tick) is set once every TICK_MS milliseconds (TICK_MS*CLK_PER_MS clock cycles), on a fixed cadence that does not drift.
- R4: An acknowledge (op 0) with pending bit 4 set returns reply byte 0 = pending AND 0x14, followed by the stored reply bytes, with length = stored count + 1. It clears only bits 4 and 2 and the stored count. Other pending bits stay set.
- R5: An acknowledge with bit 4 clear returns the whole pending byte as a one-byte reply and clears every pending bit.
- R6: An acknowledge whose argument count is nonzero is ignored: no reply is produced and pending is unchanged.
- R7: While autopoll is armed, a `poll_req` pulse is due every POLL_MS milliseconds. A due poll is skipped, with the cadence kept, while pending bit 4 is set.
- R8: A bus reply flagged as a poll result (`bus_rsp_auto`=1) with a nonzero count sets bits 4 and 2 and stores the bytes. An empty poll result sets nothing. A command reply (`bus_rsp_auto`=0) sets only bit 4, even with count 0.
- R9: Op 2 with two argument bytes and a nonzero 16-bit mask arms autopoll. A zero mask, or op 3 with no arguments, disarms it. Writing the mask that is already held leaves the poll cadence untouched.
- R10: Op 1 with exactly one argument byte replaces the mask with `cmd_arg[7:0]` on the next cycle. With any other argument count it is ignored.
- R11: An event that arrives in the same cycle as an acknowledge that clears it remains pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 acknowledge, 1 load mask, 2 set autopoll mask, 3 autopoll off |
| cmd_arg_len | input | 3 | Number of argument bytes carried |
| cmd_arg | input | 16 | Argument bytes (mask in [7:0], autopoll mask in [15:0]) |
| bus_rsp_valid | input | 1 | Bus reply ready strobe |
| bus_rsp_auto | input | 1 | Reply is the result of an autopoll |
| bus_rsp_len | input | $clog2(REPLY_MAX+1) | Reply byte count |
| bus_rsp_data | input | 8*REPLY_MAX | Reply bytes, byte i at [8i+7:8i] |
| poll_req | output | 1 | One-cycle request to run an autopoll on the bus |
| rsp_valid | output | 1 | Acknowledge reply strobe |
| rsp_len | output | $clog2(REPLY_MAX+2) | Reply length in bytes |
| rsp_data | output | 8*(REPLY_MAX+1) | Reply bytes, byte i at [8i+7:8i], unused bytes zero |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with CLK_PER_MS=4, TICK_MS=100, POLL_MS=5 and REPLY_MAX=4. With these values the tick recurs every 400 cycles and autopoll every 20 cycles. Several tick periods, exact tick and poll spacing, and a skipped poll therefore all fit into a short run. Because the tick arrives at cycles the bench can predict, each group of checks is placed right after a tick. Its expected acknowledge bytes then account for the tick bit exactly. The four-byte reply buffer also lets the zero-filled tail of the reply be checked.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    OP_ACK      = 2'd0,
    OP_SET_MASK = 2'd1,
    OP_SET_POLL = 2'd2,
    OP_POLL_OFF = 2'd3
  } evt_op_e;

  localparam int BIT_AUTO = 2;
  localparam int BIT_BUS  = 4;
  localparam int BIT_TICK = 7;

  localparam logic [7:0] BUS_PAIR   = 8'((1 << BIT_BUS) | (1 << BIT_AUTO));
  localparam logic [7:0] RESET_MASK = 8'((1 << BIT_BUS) | (1 << BIT_TICK));
endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
  parameter int CLK_PER_MS = 1000,
  parameter int TICK_MS    = 1000,
  localparam int PW = $clog2(CLK_PER_MS + 1),
  localparam int MW = $clog2(TICK_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic ms_stb,
  output logic tick
);
  logic [PW-1:0] pre_q, pre_d;
  logic [MW-1:0] ms_q, ms_d;

  always_comb begin
    ms_stb = (pre_q == PW'(CLK_PER_MS - 1));
    tick   = ms_stb && (ms_q == MW'(TICK_MS - 1));
    pre_d  = ms_stb ? '0 : pre_q + PW'(1);
    ms_d   = ms_q;
    if (tick)        ms_d = '0;
    else if (ms_stb) ms_d = ms_q + MW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end
endmodule

// File: rtl/evt_autopoll.sv
module evt_autopoll #(
  parameter int POLL_MS = 30,
  localparam int CW = $clog2(POLL_MS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ms_stb,
  input  logic        set_en,
  input  logic [15:0] set_mask,
  input  logic        off_en,
  input  logic        bus_pend,
  output logic        poll_req
);
  logic [15:0]   dmask_q, dmask_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire, armed, poll_d;

  assign armed = (dmask_q != 16'h0);

  always_comb begin
    dmask_d = dmask_q;
    cnt_d   = cnt_q;
    fire    = 1'b0;
    if (off_en) begin
      dmask_d = '0;
      cnt_d   = '0;
    end else if (set_en && (set_mask != dmask_q)) begin
      dmask_d = set_mask;
      cnt_d   = '0;
    end else if (armed && ms_stb) begin
      if (cnt_q == CW'(POLL_MS - 1)) begin
        fire  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    poll_d = fire && !bus_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmask_q  <= '0;
      cnt_q    <= '0;
      poll_req <= 1'b0;
    end else begin
      dmask_q  <= dmask_d;
      cnt_q    <= cnt_d;
      poll_req <= poll_d;
    end
  end
endmodule

// File: rtl/evt_pending.sv
module evt_pending
  import evt_pkg::*;
#(
  parameter int REPLY_MAX = 8,
  localparam int LW = $clog2(REPLY_MAX + 1),
  localparam int RW = $clog2(REPLY_MAX + 2),
  localparam int BW = 8 * REPLY_MAX,
  localparam int OW = 8 * (REPLY_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_vld,
  input  logic          bus_auto,
  input  logic [LW-1:0] bus_len,
  input  logic [BW-1:0] bus_data,
  input  logic          ack_ok,
  input  logic          mask_wr,
  input  logic [7:0]    mask_val,
  output logic [7:0]    pend_q,
  output logic [7:0]    mask_q,
  output logic          rsp_valid,
  output logic [RW-1:0] rsp_len,
  output logic [OW-1:0] rsp_data
);
  logic [7:0]    pend_d, mask_d, set_vec, clr_vec, head;
  logic [LW-1:0] len_q, len_d, len_in;
  logic [BW-1:0] buf_q, buf_d, body;
  logic          take_cmd, take_poll;
  logic [RW-1:0] rsp_len_d;

  for (genvar g = 0; g < REPLY_MAX; g++) begin : g_body
    assign body[8*g +: 8] = (pend_q[BIT_BUS] && (g < int'(len_q))) ? buf_q[8*g +: 8] : 8'h00;
  end

  always_comb begin
    take_cmd  = bus_vld && !bus_auto;
    take_poll = bus_vld && bus_auto && (bus_len != '0) && !pend_q[BIT_BUS];
    len_in    = (bus_len > LW'(REPLY_MAX)) ? LW'(REPLY_MAX) : bus_len;

    set_vec = 8'h00;
    if (tick)                   set_vec[BIT_TICK] = 1'b1;
    if (take_cmd || take_poll)  set_vec[BIT_BUS]  = 1'b1;
    if (take_poll)              set_vec[BIT_AUTO] = 1'b1;

    clr_vec = 8'h00;
    if (ack_ok) clr_vec = pend_q[BIT_BUS] ? BUS_PAIR : 8'hFF;

    pend_d = (pend_q & ~clr_vec) | set_vec;
    mask_d = mask_wr ? mask_val : mask_q;

    len_d = len_q;
    buf_d = buf_q;
    if (take_cmd || take_poll) begin
      len_d = len_in;
      buf_d = bus_data;
    end else if (ack_ok && pend_q[BIT_BUS]) begin
      len_d = '0;
    end

    head      = pend_q[BIT_BUS] ? (pend_q & BUS_PAIR) : pend_q;
    rsp_len_d = pend_q[BIT_BUS] ? (RW'(len_q) + RW'(1)) : RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 8'h00;
      mask_q    <= RESET_MASK;
      len_q     <= '0;
      buf_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_len   <= '0;
      rsp_data  <= '0;
    end else begin
      pend_q    <= pend_d;
      mask_q    <= mask_d;
      len_q     <= len_d;
      buf_q     <= buf_d;
      rsp_valid <= ack_ok;
      if (ack_ok) begin
        rsp_len  <= rsp_len_d;
        rsp_data <= {body, head};
      end
    end
  end

  AST_ACK_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !pend_q[BIT_BUS] && !tick && !bus_vld) |=> (pend_q == 8'h00)); // R5
  AST_ACK_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && pend_q[BIT_BUS] && !tick && !bus_vld) |=> (pend_q == ($past(pend_q) & ~BUS_PAIR))); // R4
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_val))); // R10
  AST_TICK_SURVIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && tick) |=> pend_q[BIT_TICK]); // R11
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_pkg::*;
#(
  parameter int CLK_PER_MS = 1000,
  parameter int TICK_MS    = 1000,
  parameter int POLL_MS    = 30,
  parameter int REPLY_MAX  = 8,
  localparam int LW = $clog2(REPLY_MAX + 1),
  localparam int RW = $clog2(REPLY_MAX + 2)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [2:0]                   cmd_arg_len,
  input  logic [15:0]                  cmd_arg,
  input  logic                         bus_rsp_valid,
  input  logic                         bus_rsp_auto,
  input  logic [LW-1:0]                bus_rsp_len,
  input  logic [8*REPLY_MAX-1:0]       bus_rsp_data,
  output logic                         poll_req,
  output logic                         rsp_valid,
  output logic [RW-1:0]                rsp_len,
  output logic [8*(REPLY_MAX+1)-1:0]   rsp_data,
  output logic                         irq_n
);
  logic [1:0] rst_pipe;
  logic       rst_s;
  logic       ack_ok, mask_wr, poll_set, poll_off;
  logic       ms_stb, tick;
  logic [7:0] pend, mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  always_comb begin
    ack_ok   = cmd_valid && (cmd_op == OP_ACK)      && (cmd_arg_len == 3'd0);
    mask_wr  = cmd_valid && (cmd_op == OP_SET_MASK) && (cmd_arg_len == 3'd1);
    poll_set = cmd_valid && (cmd_op == OP_SET_POLL) && (cmd_arg_len == 3'd2);
    poll_off = cmd_valid && (cmd_op == OP_POLL_OFF) && (cmd_arg_len == 3'd0);
  end

  evt_tick_gen #(.CLK_PER_MS(CLK_PER_MS), .TICK_MS(TICK_MS)) u_tick (
    .clk(clk), .rst_n(rst_s), .ms_stb(ms_stb), .tick(tick)
  );

  evt_autopoll #(.POLL_MS(POLL_MS)) u_poll (
    .clk(clk), .rst_n(rst_s), .ms_stb(ms_stb),
    .set_en(poll_set), .set_mask(cmd_arg), .off_en(poll_off),
    .bus_pend(pend[BIT_BUS]), .poll_req(poll_req)
  );

  evt_pending #(.REPLY_MAX(REPLY_MAX)) u_pend (
    .clk(clk), .rst_n(rst_s), .tick(tick),
    .bus_vld(bus_rsp_valid), .bus_auto(bus_rsp_auto),
    .bus_len(bus_rsp_len), .bus_data(bus_rsp_data),
    .ack_ok(ack_ok), .mask_wr(mask_wr), .mask_val(cmd_arg[7:0]),
    .pend_q(pend), .mask_q(mask),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data)
  );

  assign irq_n = ~|(pend & mask);

  AST_RSP_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_valid |-> $past(cmd_valid && (cmd_op == 2'd0) && (cmd_arg_len == 3'd0))); // R6
  AST_POLL_STOPS: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && (((cmd_op == 2'd3) && (cmd_arg_len == 3'd0)) ||
     ((cmd_op == 2'd2) && (cmd_arg_len == 3'd2) && (cmd_arg == 16'h0))))
    |-> ##2 !poll_req); // R9
  AST_POLL_SKIPPED_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    (pend[BIT_BUS] && $past(pend[BIT_BUS])) |-> !poll_req); // R7
endmodule

// File: tb/tb_evt_irq_ctrl.sv
`timescale 1ns/1ps
module tb_evt_irq_ctrl;
  localparam int CPM = 4, TMS = 100, PMS = 5, RMAX = 4;
  localparam int TICK_CYC = CPM * TMS;
  localparam int POLL_CYC = CPM * PMS;
  localparam int LW = $clog2(RMAX + 1);
  localparam int RW = $clog2(RMAX + 2);

  // table entry: {mask byte, argument count, expected irq_n}
  localparam logic [11:0] VEC [6] = '{
    {8'h00, 3'd1, 1'b1}, {8'h10, 3'd1, 1'b0}, {8'hEF, 3'd1, 1'b1},
    {8'hFF, 3'd2, 1'b1}, {8'hFF, 3'd0, 1'b1}, {8'h10, 3'd1, 1'b0}};

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, bus_rsp_valid, bus_rsp_auto;
  logic [1:0] cmd_op;
  logic [2:0] cmd_arg_len;
  logic [15:0] cmd_arg;
  logic [LW-1:0] bus_rsp_len;
  logic [8*RMAX-1:0] bus_rsp_data;
  logic poll_req, rsp_valid, irq_n;
  logic [RW-1:0] rsp_len;
  logic [8*(RMAX+1)-1:0] rsp_data;

  int checks = 0, fails = 0, cyc = 0, anchor = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  evt_irq_ctrl #(.CLK_PER_MS(CPM), .TICK_MS(TMS), .POLL_MS(PMS), .REPLY_MAX(RMAX)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg_len(cmd_arg_len), .cmd_arg(cmd_arg), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_auto(bus_rsp_auto), .bus_rsp_len(bus_rsp_len), .bus_rsp_data(bus_rsp_data),
    .poll_req(poll_req), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
    .rsp_data(rsp_data), .irq_n(irq_n));

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_cmd(logic [1:0] op, logic [2:0] len, logic [15:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg_len = len; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic bus_reply(logic auto_f, logic [LW-1:0] len, logic [8*RMAX-1:0] data);
    @(negedge clk);
    bus_rsp_valid = 1'b1; bus_rsp_auto = auto_f; bus_rsp_len = len; bus_rsp_data = data;
    @(negedge clk);
    bus_rsp_valid = 1'b0;
  endtask

  task automatic do_ack(string req, int exp_len, logic [39:0] exp_data);
    send_cmd(2'd0, 3'd0, 16'h0);
    check(req, "rsp_valid", rsp_valid, 1);
    check(req, "rsp_len", rsp_len, exp_len);
    check(req, "rsp_data", rsp_data, exp_data);
  endtask

  task automatic wait_poll(output int t);
    do @(negedge clk); while (!poll_req);
    t = cyc;
  endtask

  task automatic count_polls(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (poll_req) c++;
    end
  endtask

  task automatic wait_tick();
    while (cyc < anchor + TICK_CYC) @(negedge clk);
    anchor = anchor + TICK_CYC;
    check("R3", "irq_n at scheduled tick", irq_n, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int t1, t2, p1, p2, p3, c;
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_arg_len = 0; cmd_arg = 0;
    bus_rsp_valid = 0; bus_rsp_auto = 0; bus_rsp_len = 0; bus_rsp_data = 0;
    repeat (3) @(negedge clk);
    check("R2", "irq_n in reset", irq_n, 1);
    check("R2", "rsp_valid in reset", rsp_valid, 0);
    check("R2", "poll_req in reset", poll_req, 0);
    rst_n = 1'b1;
    count_polls(40, c);
    check("R2", "no poll after reset", c, 0);
    check("R2", "irq_n idle", irq_n, 1);

    // tick cadence; irq firing shows the tick bit is enabled at reset (R2)
    do @(negedge clk); while (irq_n);
    t1 = cyc;
    do_ack("R5", 1, 40'h80);
    check("R1", "irq_n released after ack", irq_n, 1);
    do @(negedge clk); while (irq_n);
    t2 = cyc;
    check("R3", "tick spacing", t2 - t1, TICK_CYC);
    do_ack("R5", 1, 40'h80);
    anchor = t2;

    // table: mask loads against a pending bus bit
    bus_reply(1'b0, LW'(2), 32'h0000BBAA);
    check("R8", "irq_n after command reply", irq_n, 0);
    for (int i = 0; i < 6; i++) begin
      send_cmd(2'd1, VEC[i][3:1], {8'h00, VEC[i][11:4]});
      check("R10", $sformatf("irq_n entry %0d", i), irq_n, VEC[i][0]);
    end
    do_ack("R4", 3, 40'h0000BBAA10);
    check("R1", "irq_n after bus ack", irq_n, 1);
    send_cmd(2'd1, 3'd1, 16'h0090);

    // ack with arguments ignored
    bus_reply(1'b0, LW'(0), 32'h0);
    send_cmd(2'd0, 3'd1, 16'h0);
    check("R6", "no reply for bad ack", rsp_valid, 0);
    check("R6", "irq_n kept", irq_n, 0);
    do_ack("R8", 1, 40'h10);

    // priority of bus reply over tick
    wait_tick();
    bus_reply(1'b0, LW'(1), 32'h000000CC);
    do_ack("R4", 2, 40'h000000CC10);
    check("R4", "tick still pending", irq_n, 0);
    do_ack("R5", 1, 40'h80);

    // event arriving with the clearing ack
    wait_tick();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_arg_len = 3'd0;
    bus_rsp_valid = 1'b1; bus_rsp_auto = 1'b0; bus_rsp_len = LW'(1); bus_rsp_data = 32'h000000DD;
    @(negedge clk);
    cmd_valid = 1'b0; bus_rsp_valid = 1'b0;
    check("R11", "ack reply byte", rsp_data, 40'h80);
    check("R11", "new bus event pending", irq_n, 0);
    do_ack("R11", 2, 40'h000000DD10);

    // autopoll
    wait_tick();
    do_ack("R5", 1, 40'h80);
    send_cmd(2'd2, 3'd2, 16'hFFFF);
    wait_poll(p1);
    bus_reply(1'b1, LW'(0), 32'h0);
    check("R8", "empty poll sets nothing", irq_n, 1);
    wait_poll(p2);
    check("R7", "poll spacing", p2 - p1, POLL_CYC);
    repeat (8) @(negedge clk);
    send_cmd(2'd2, 3'd2, 16'hFFFF);
    wait_poll(p3);
    check("R9", "same mask keeps cadence", p3 - p2, POLL_CYC);
    bus_reply(1'b1, LW'(2), 32'h00002211);
    check("R8", "poll data raises irq", irq_n, 0);
    count_polls(30, c);
    check("R7", "poll skipped while bus pending", c, 0);
    do_ack("R8", 3, 40'h0000221114);
    send_cmd(2'd3, 3'd0, 16'h0);
    count_polls(60, c);
    check("R9", "poll off stops polls", c, 0);
    send_cmd(2'd2, 3'd2, 16'h0001);
    wait_poll(p1);
    bus_reply(1'b1, LW'(0), 32'h0);
    send_cmd(2'd2, 3'd2, 16'h0000);
    count_polls(60, c);
    check("R9", "zero mask stops polls", c, 0);
    check("R1", "irq_n idle at end", irq_n, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule